// File: doc/BRIEF.md
# Periodic Forced-Reset Scheduler

This block counts down a fixed interval of prescaled ticks and, when the count runs out, issues a reset pulse to the rest of the system. Software has no way to stop, pause or reload the countdown. It can read how many ticks are left before the next forced reset. It can also bring that reset forward by writing a fixed key on the early-request strobe.

Once the pulse ends, the counter restarts itself from the full interval. A system reset that reaches the block from anywhere else also restarts it. A small cause code records whether the most recent reset came from this scheduler, and whether that reset was the scheduled expiry or an early request. The cause code survives the system reset that the scheduler itself caused. Software reads it after restart and clears it with a strobe. Only the power-on reset clears every piece of state.

Top module: `periodic_reset_sched`

## Requirements
- R1: After `por_n` is released, `remaining` equals INTERVAL, `rst_pulse` is 0 and `cause_code` is 2'b00.
- R2: While no pulse is active and `sys_rst_n` is high, each clock with `tick_en` high lowers `remaining` by one. The tick taken while `remaining` is 1 starts the pulse on the next cycle, so a forced reset comes exactly INTERVAL ticks after any restart.
- R3: Outside a pulse with `sys_rst_n` high, `remaining` never increases and never exceeds INTERVAL. It holds its value in any cycle that has neither a tick nor a valid early request.
- R4: An `early_req` whose `early_key` equals KEY starts the pulse on the next cycle, whatever `remaining` is.
- R5: An `early_req` with any other key value has no effect on `remaining`, `rst_pulse` or `cause_code`.
- R6: `rst_pulse` stays high for exactly PULSE_CYC consecutive cycles. While it is high, `remaining` reads 0, and ticks and early requests are ignored.
- R7: In the first cycle after `rst_pulse` falls, `remaining` equals INTERVAL.
- R8: `sys_rst_n` low outside a pulse reloads `remaining` to INTERVAL and clears `cause_code` to 2'b00 on the next cycle. `sys_rst_n` low during a pulse has no effect.
- R9: `cause_code` becomes 2'b01 (expiry) or 2'b10 (early request) in the same cycle the pulse starts. If both causes occur in one cycle, it records 2'b01. `clr_cause` clears it to 2'b00 on the next cycle, unless a pulse starts in that same cycle, in which case the new cause wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears all state |
| sys_rst_n | input | 1 | System reset seen by the block, active low, sampled synchronously; restarts the count |
| tick_en | input | 1 | Prescaled tick, one count per high cycle |
| early_req | input | 1 | Early-reset request strobe |
| early_key | input | KEY_W | Key presented with the early request |
| clr_cause | input | 1 | Clears the cause code |
| rst_pulse | output | 1 | Forced reset request, high for PULSE_CYC cycles |
| remaining | output | $clog2(INTERVAL+1) | Ticks left before the forced reset |
| cause_code | output | 2 | 00 none, 01 expiry, 10 early request |

## Verification
Every output is registered. A tick, an early request, a clear or a system reset sampled on one rising edge therefore shows up on `remaining`, `rst_pulse` and `cause_code` immediately after that edge. The pulse then lasts PULSE_CYC cycles, and the reload is visible in the first cycle after it falls. The bench changes inputs only just after a falling edge and reads the outputs at the next falling edge. Each result is checked exactly one cycle after its stimulus, and the pulse length is checked by counting falling-edge samples.

// File: rtl/prs_pkg.sv
package prs_pkg;
  typedef enum logic [1:0] {
    CAUSE_NONE   = 2'b00,
    CAUSE_EXPIRY = 2'b01,
    CAUSE_EARLY  = 2'b10
  } cause_e;
endpackage

// File: rtl/prs_countdown.sv
module prs_countdown #(
  parameter int INTERVAL = 1000000,
  parameter int CW       = $clog2(INTERVAL + 1)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          sys_rst_n,
  input  logic          tick_en,
  input  logic          busy,
  input  logic          reload,
  input  logic          early_fire,
  output logic [CW-1:0] left,
  output logic          expire
);
  localparam logic [CW-1:0] FULL = CW'(INTERVAL);
  localparam logic [CW-1:0] ONE  = CW'(1);

  // expiry is the tick that consumes the last count
  assign expire = !busy && sys_rst_n && tick_en && (left == ONE);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      left <= FULL;
    end else if (busy) begin
      left <= reload ? FULL : '0;
    end else if (!sys_rst_n) begin
      left <= FULL;
    end else if (expire || early_fire) begin
      left <= '0;
    end else if (tick_en) begin
      left <= left - ONE;
    end
  end
endmodule

// File: rtl/prs_key_gate.sv
module prs_key_gate #(
  parameter int               KEY_W = 16,
  parameter logic [KEY_W-1:0] KEY   = 16'hC3A5
) (
  input  logic             early_req,
  input  logic [KEY_W-1:0] early_key,
  input  logic             busy,
  input  logic             sys_rst_n,
  output logic             early_fire
);
  logic key_ok;

  assign key_ok     = (early_key == KEY);
  assign early_fire = early_req && key_ok && !busy && sys_rst_n;
endmodule

// File: rtl/prs_pulse_gen.sv
module prs_pulse_gen #(
  parameter int PULSE_CYC = 16,
  parameter int PW        = $clog2(PULSE_CYC + 1)
) (
  input  logic clk,
  input  logic por_n,
  input  logic fire,
  output logic busy,
  output logic last
);
  localparam logic [PW-1:0] LEN = PW'(PULSE_CYC);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] pc;

  assign busy = (pc != '0);
  assign last = (pc == ONE);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pc <= '0;
    end else if (busy) begin
      pc <= pc - ONE;
    end else if (fire) begin
      pc <= LEN;
    end
  end
endmodule

// File: rtl/prs_cause_flag.sv
module prs_cause_flag
  import prs_pkg::*;
(
  input  logic   clk,
  input  logic   por_n,
  input  logic   fire_exp,
  input  logic   fire_early,
  input  logic   clr,
  input  logic   ext_rst,
  output cause_e code
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      code <= CAUSE_NONE;
    end else if (fire_exp) begin
      code <= CAUSE_EXPIRY;
    end else if (fire_early) begin
      code <= CAUSE_EARLY;
    end else if (clr || ext_rst) begin
      code <= CAUSE_NONE;
    end
  end
endmodule

// File: rtl/periodic_reset_sched.sv
module periodic_reset_sched
  import prs_pkg::*;
#(
  parameter int               INTERVAL  = 1000000,
  parameter int               PULSE_CYC = 16,
  parameter int               KEY_W     = 16,
  parameter logic [KEY_W-1:0] KEY       = 16'hC3A5,
  localparam int              CW        = $clog2(INTERVAL + 1)
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             sys_rst_n,
  input  logic             tick_en,
  input  logic             early_req,
  input  logic [KEY_W-1:0] early_key,
  input  logic             clr_cause,
  output logic             rst_pulse,
  output logic [CW-1:0]    remaining,
  output logic [1:0]       cause_code
);
  logic   busy;
  logic   last;
  logic   expire;
  logic   early_fire;
  cause_e code;

  prs_key_gate #(.KEY_W(KEY_W), .KEY(KEY)) u_key (
    .early_req (early_req),
    .early_key (early_key),
    .busy      (busy),
    .sys_rst_n (sys_rst_n),
    .early_fire(early_fire)
  );

  prs_countdown #(.INTERVAL(INTERVAL), .CW(CW)) u_cnt (
    .clk       (clk),
    .por_n     (por_n),
    .sys_rst_n (sys_rst_n),
    .tick_en   (tick_en),
    .busy      (busy),
    .reload    (last),
    .early_fire(early_fire),
    .left      (remaining),
    .expire    (expire)
  );

  prs_pulse_gen #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk  (clk),
    .por_n(por_n),
    .fire (expire || early_fire),
    .busy (busy),
    .last (last)
  );

  prs_cause_flag u_cause (
    .clk       (clk),
    .por_n     (por_n),
    .fire_exp  (expire),
    .fire_early(early_fire),
    .clr       (clr_cause),
    .ext_rst   (!sys_rst_n && !busy),
    .code      (code)
  );

  assign rst_pulse  = busy;
  assign cause_code = code;
endmodule

// File: rtl/periodic_reset_sched_chk.sv
module periodic_reset_sched_chk #(
  parameter int               INTERVAL  = 1000000,
  parameter int               PULSE_CYC = 16,
  parameter int               KEY_W     = 16,
  parameter logic [KEY_W-1:0] KEY       = 16'hC3A5,
  parameter int               CW        = $clog2(INTERVAL + 1)
) (
  input logic             clk,
  input logic             por_n,
  input logic             sys_rst_n,
  input logic             tick_en,
  input logic             early_req,
  input logic [KEY_W-1:0] early_key,
  input logic             rst_pulse,
  input logic [CW-1:0]    remaining,
  input logic [1:0]       cause_code
);
  localparam int            RW   = $clog2(PULSE_CYC + 2);
  localparam logic [CW-1:0] FULL = CW'(INTERVAL);

  logic [RW-1:0] run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)         run <= '0;
    else if (rst_pulse) run <= run + RW'(1);
    else                run <= '0;
  end

  assert_pulse_len_R6: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_pulse) |-> (run == RW'(PULSE_CYC)));

  assert_pulse_zero_R6: assert property (@(posedge clk) disable iff (!por_n)
    rst_pulse |-> (remaining == '0));

  assert_no_above_full_R3: assert property (@(posedge clk) disable iff (!por_n)
    remaining <= FULL);

  assert_no_extend_R3: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_pulse && sys_rst_n) |=> (remaining <= $past(remaining)));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_pulse && sys_rst_n && !tick_en && !(early_req && early_key == KEY))
      |=> $stable(remaining));

  assert_key_fire_R4: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_pulse && sys_rst_n && early_req && early_key == KEY) |=> rst_pulse);

  assert_bad_key_R5: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_pulse && sys_rst_n && !tick_en && early_req && early_key != KEY)
      |=> !rst_pulse);

  assert_restart_R7: assert property (@(posedge clk) disable iff (!por_n)
    $fell(rst_pulse) |-> (remaining == FULL));

  assert_sys_reload_R8: assert property (@(posedge clk) disable iff (!por_n)
    (!rst_pulse && !sys_rst_n) |=> (remaining == FULL && cause_code == 2'b00));

  assert_cause_set_R9: assert property (@(posedge clk) disable iff (!por_n)
    $rose(rst_pulse) |-> (cause_code != 2'b00));
endmodule

bind periodic_reset_sched periodic_reset_sched_chk #(
  .INTERVAL(INTERVAL), .PULSE_CYC(PULSE_CYC), .KEY_W(KEY_W), .KEY(KEY), .CW(CW)
) u_chk (
  .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick_en(tick_en),
  .early_req(early_req), .early_key(early_key), .rst_pulse(rst_pulse),
  .remaining(remaining), .cause_code(cause_code)
);

// File: tb/tb_periodic_reset_sched.sv
`timescale 1ns/1ps
module tb_periodic_reset_sched;
  localparam int        IV  = 12;
  localparam int        PL  = 3;
  localparam logic [7:0] KY = 8'hA5;

  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       sys_rst_n = 1'b1;
  logic       tick_en = 1'b0;
  logic       early_req = 1'b0;
  logic [7:0] early_key = 8'h00;
  logic       clr_cause = 1'b0;
  logic       rst_pulse;
  logic [3:0] remaining;
  logic [1:0] cause_code;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  periodic_reset_sched #(.INTERVAL(IV), .PULSE_CYC(PL), .KEY_W(8), .KEY(KY)) dut (
    .clk(clk), .por_n(por_n), .sys_rst_n(sys_rst_n), .tick_en(tick_en),
    .early_req(early_req), .early_key(early_key), .clr_cause(clr_cause),
    .rst_pulse(rst_pulse), .remaining(remaining), .cause_code(cause_code)
  );

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string tag, input string what, input int act, input int exp);
    chk(act == exp, tag, what, act, exp);
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    for (int i = 0; i < n; i++) cyc();
    tick_en = 1'b0;
  endtask

  task automatic good_early();
    early_req = 1'b1; early_key = KY;
    cyc();
    early_req = 1'b0; early_key = 8'h00;
  endtask

  // waits out a pulse already seen high once; checks length and restart
  task automatic finish_pulse(input string tag);
    int high = 1;
    for (int i = 0; i < PL + 2; i++) begin
      cyc();
      if (rst_pulse) high++;
      else break;
    end
    chk_eq("R6", {tag, " pulse length"}, high, PL);
    chk_eq("R7", {tag, " reload after pulse"}, remaining, IV);
  endtask

  task automatic t_reset();
    chk_eq("R1", "remaining after por", remaining, IV);
    chk_eq("R1", "pulse after por", rst_pulse, 0);
    chk_eq("R1", "cause after por", cause_code, 0);
  endtask

  task automatic t_countdown();
    ticks(5);
    chk_eq("R2", "after 5 ticks", remaining, IV - 5);
    repeat (3) cyc();
    chk_eq("R3", "hold without tick", remaining, IV - 5);
    ticks(6);
    chk_eq("R2", "one left", remaining, 1);
    chk_eq("R2", "no pulse yet", rst_pulse, 0);
    tick_en = 1'b1;
    cyc();
    chk_eq("R2", "expiry pulse", rst_pulse, 1);
    chk_eq("R6", "zero during pulse", remaining, 0);
    chk_eq("R9", "cause expiry", cause_code, 1);
    // tick and a valid early request during the pulse must be ignored
    early_req = 1'b1; early_key = KY;
    cyc();
    early_req = 1'b0; tick_en = 1'b0;
    chk_eq("R6", "still pulsing", rst_pulse, 1);
    cyc();
    if (rst_pulse) begin
      cyc();
      chk_eq("R6", "pulse ends after length", rst_pulse, 0);
      chk_eq("R7", "restart full", remaining, IV);
    end else begin
      chk_eq("R6", "pulse too short", 0, 1);
    end
    chk_eq("R9", "cause kept", cause_code, 1);
  endtask

  task automatic t_clear();
    clr_cause = 1'b1;
    cyc();
    clr_cause = 1'b0;
    chk_eq("R9", "cleared cause", cause_code, 0);
  endtask

  task automatic t_bad_key();
    early_req = 1'b1; early_key = 8'h5A;
    cyc();
    early_req = 1'b0; early_key = 8'h00;
    chk_eq("R5", "no pulse on bad key", rst_pulse, 0);
    chk_eq("R5", "remaining untouched", remaining, IV);
    chk_eq("R5", "cause untouched", cause_code, 0);
  endtask

  task automatic t_good_key();
    ticks(2);
    good_early();
    chk_eq("R4", "early pulse", rst_pulse, 1);
    chk_eq("R4", "zero on early", remaining, 0);
    chk_eq("R9", "cause early", cause_code, 2);
    finish_pulse("early");
  endtask

  task automatic t_sys_reset();
    ticks(4);
    chk_eq("R8", "pre-reset count", remaining, IV - 4);
    sys_rst_n = 1'b0;
    cyc();
    sys_rst_n = 1'b1;
    chk_eq("R8", "sys reset reload", remaining, IV);
    chk_eq("R8", "sys reset clears cause", cause_code, 0);
    good_early();
    chk_eq("R4", "second early pulse", rst_pulse, 1);
    sys_rst_n = 1'b0;
    cyc();
    cyc();
    sys_rst_n = 1'b1;
    chk_eq("R8", "pulse survives sys reset", rst_pulse, 1);
    cyc();
    chk_eq("R8", "pulse ends on time", rst_pulse, 0);
    chk_eq("R8", "reload after pulse", remaining, IV);
    chk_eq("R8", "cause survives own reset", cause_code, 2);
  endtask

  task automatic t_tie();
    ticks(IV - 1);
    tick_en = 1'b1; early_req = 1'b1; early_key = KY;
    cyc();
    tick_en = 1'b0; early_req = 1'b0; early_key = 8'h00;
    chk_eq("R9", "tie records expiry", cause_code, 1);
    finish_pulse("tie");
  endtask

  task automatic t_clear_vs_fire();
    ticks(IV - 1);
    tick_en = 1'b1; clr_cause = 1'b1;
    cyc();
    tick_en = 1'b0; clr_cause = 1'b0;
    chk_eq("R2", "pulse on expiry", rst_pulse, 1);
    chk_eq("R9", "fire beats clear", cause_code, 1);
    finish_pulse("clear race");
  endtask

  initial begin
    repeat (3) cyc();
    por_n = 1'b1;
    cyc();
    t_reset();
    t_countdown();
    t_clear();
    t_bad_key();
    t_good_key();
    t_sys_reset();
    t_tie();
    t_clear_vs_fire();
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule